// File: doc/BRIEF.md
# Skid-Buffered Stage Flow Controller

This block is the flow control for one thread of one pipeline stage. Each cycle it may receive a group of up to `IN_W` opaque instruction tags from the stage above. It forwards at most `OUT_W` of them per cycle to the stage below. Stall requests come from three downstream stages. While any of them holds a stall, the controller stops forwarding and parks every arriving tag in a circular skid buffer. When the stalls clear, it drains that buffer oldest-first before fresh input flows straight through again. It tells the stage above to stop and to resume through single-cycle hold and release pulses.

A flush from the retire stage overrides everything else. It empties the skid buffer and discards the input of that cycle. A "flush still in progress" indication from the same stage keeps the controller in its squashing state. Tags that arrive already marked squashed are dropped and take no output slot. The skid buffer holds `UP_DLY*IN_W + OUT_W` entries, which covers the tags still in flight from upstream after a hold pulse, plus one output group. An overflow sets a sticky error flag.

All outputs are registered. A decision taken at a clock edge from that cycle's inputs appears on the outputs right after that edge. The state encoding is Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.

Top module: `skid_stage_ctl`

## Requirements
- R1: After reset, `state` is 0 (Idle) and `out_valid`, `up_hold`, `up_release` and `ovf_err` are all 0. An Idle controller with no live input stays Idle.
- R2: With no stall and an empty skid buffer, live input tags are forwarded on the clock edge that samples them. Slot k is `out_tags[k*TAG_W +: TAG_W]`, slot 0 carries the oldest tag, and `out_valid` sets its low bits contiguously. The state becomes Running (1).
- R3: An input entry whose bit in `in_squashed` is 1 is discarded without using an output slot or a skid entry. The live entries after it move up to fill its place.
- R4: If a Running cycle has more than `OUT_W` live tags, the first `OUT_W` are forwarded and the rest go into the skid buffer. `up_hold` pulses and the state becomes Blocked (2).
- R5: Stall flag i is set by `dn_hold[i]` and cleared by `dn_release[i]`; release wins if both are pulsed together. While any flag is set after that cycle's pulses, nothing is forwarded, live input is appended to the skid buffer and the state is Blocked. `up_hold` pulses only if the state was neither Blocked nor Unblocking.
- R6: In the first cycle with all flags clear, a Blocked thread starts draining. Each cycle it forwards up to `OUT_W` tags from the skid buffer, oldest first, and appends that cycle's live input behind them. Fresh input is never forwarded directly. While entries remain, the state is Unblocking (3).
- R7: On the cycle the skid buffer becomes empty during a drain, `up_release` pulses and the state becomes Running.
- R8: `flush` has priority over stalls. It empties the skid buffer, discards the input of that cycle, forwards nothing and sets the state to Squashing (4). `up_release` pulses if the state was Blocked or Unblocking.
- R9: While `flush_busy` is 1, the state stays Squashing and input is discarded. On the first cycle with neither flush nor stall, the state becomes Running and that cycle's live input is forwarded.
- R10: The skid buffer holds `UP_DLY*IN_W + OUT_W` tags. Tags that do not fit are dropped, and `ovf_err` goes to 1 and stays 1 until reset.
- R11: `up_hold` and `up_release` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream group present |
| in_count | input | $clog2(IN_W+1) | Number of entries in the group |
| in_squashed | input | IN_W | Per-entry already-squashed mark |
| in_tags | input | IN_W*TAG_W | Entry tags, entry 0 oldest |
| dn_hold | input | 3 | Stall-set pulses from the three downstream stages |
| dn_release | input | 3 | Stall-clear pulses from the three downstream stages |
| flush | input | 1 | Flush command from the retire stage |
| flush_busy | input | 1 | Retire stage reports the flush still in progress |
| out_valid | output | OUT_W | Valid bit per output slot |
| out_tags | output | OUT_W*TAG_W | Forwarded tags, slot 0 oldest |
| up_hold | output | 1 | Pulse asking upstream to stop |
| up_release | output | 1 | Pulse allowing upstream to resume |
| state | output | 3 | Current controller state |
| ovf_err | output | 1 | Sticky skid overflow flag |

## Verification
The assertions check the following on every cycle. The hold and release pulses never coincide, and a hold is never resent while already holding. A release only appears with an empty skid buffer. A stall or a flush always yields an empty output the next cycle. Each stall flag follows its own pulses, and the skid level stays within capacity with no pop beyond it. The error flag is sticky. Tag ordering across a stall, the appending of input during a drain, the discarding of flushed and pre-squashed tags, and the exact cycle of each state change can only be shown by the bench's scenarios. There a scoreboard holds the order in which tags must emerge.

// File: rtl/skid_stage_pkg.sv
package skid_stage_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_HOLD  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_FLUSH = 3'd4
  } stage_st_e;

  localparam int NUM_DN = 3;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/stall_flags.sv
module stall_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_p,
  input  logic [N-1:0] clr_p,
  output logic [N-1:0] flags_nx,
  output logic [N-1:0] flags_q
);

  assign flags_nx = (flags_q | set_p) & ~clr_p;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_nx;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
      (set_p[i] && !clr_p[i]) |=> flags_q[i]); // R5
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
      clr_p[i] |=> !flags_q[i]); // R5
  end

endmodule

// File: rtl/live_pack.sv
module live_pack #(
  parameter int TAG_W = 8,
  parameter int IN_W  = 4,
  localparam int CW   = $clog2(IN_W + 1)
) (
  input  logic [CW-1:0]         in_count,
  input  logic                  in_valid,
  input  logic [IN_W-1:0]       in_squashed,
  input  logic [IN_W*TAG_W-1:0] in_tags,
  output logic [IN_W*TAG_W-1:0] live_tags,
  output logic [CW-1:0]         live_cnt
);

  int idx;

  always_comb begin
    idx = 0;
    live_tags = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (in_valid && (i < int'(in_count)) && !in_squashed[i]) begin
        live_tags[idx*TAG_W +: TAG_W] = in_tags[i*TAG_W +: TAG_W];
        idx = idx + 1;
      end
    end
    live_cnt = CW'(idx);
  end

endmodule

// File: rtl/skid_ring.sv
module skid_ring #(
  parameter int TAG_W = 8,
  parameter int IN_W  = 4,
  parameter int OUT_W = 2,
  parameter int DEPTH = 10,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int ICW  = $clog2(IN_W + 1),
  localparam int OCW  = $clog2(OUT_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic [ICW-1:0]         push_n,
  input  logic [IN_W*TAG_W-1:0]  push_data,
  input  logic [OCW-1:0]         pop_n,
  output logic [OUT_W*TAG_W-1:0] rd_data,
  output logic [LW-1:0]          level,
  output logic                   ovf
);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PW-1:0]    head, tail;
  int               space, acc;

  function automatic logic [PW-1:0] wrap(input int v);
    int s;
    s = v;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  always_comb begin
    space = DEPTH - int'(level) + int'(pop_n);
    acc   = (int'(push_n) > space) ? space : int'(push_n);
    ovf   = int'(push_n) > space;
  end

  always_comb begin
    for (int i = 0; i < OUT_W; i++)
      rd_data[i*TAG_W +: TAG_W] = mem[wrap(int'(head) + i)];
  end

  always_ff @(posedge clk) begin
    if (!rst && !clear) begin
      for (int i = 0; i < IN_W; i++)
        if (i < acc) mem[wrap(int'(tail) + i)] <= push_data[i*TAG_W +: TAG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else begin
      tail  <= wrap(int'(tail) + acc);
      head  <= wrap(int'(head) + int'(pop_n));
      level <= LW'(int'(level) - int'(pop_n) + acc);
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH); // R10
  AST_POP_AVAIL: assert property (@(posedge clk) disable iff (rst)
    pop_n <= OCW'(level) || int'(level) >= OUT_W); // R6

endmodule

// File: rtl/skid_stage_ctl.sv
module skid_stage_ctl
  import skid_stage_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int IN_W   = 4,
  parameter int OUT_W  = 2,
  parameter int UP_DLY = 2,
  localparam int CW    = $clog2(IN_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [CW-1:0]          in_count,
  input  logic [IN_W-1:0]        in_squashed,
  input  logic [IN_W*TAG_W-1:0]  in_tags,
  input  logic [2:0]             dn_hold,
  input  logic [2:0]             dn_release,
  input  logic                   flush,
  input  logic                   flush_busy,
  output logic [OUT_W-1:0]       out_valid,
  output logic [OUT_W*TAG_W-1:0] out_tags,
  output logic                   up_hold,
  output logic                   up_release,
  output logic [2:0]             state,
  output logic                   ovf_err
);

  localparam int DEPTH = UP_DLY * IN_W + OUT_W;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int OCW   = $clog2(OUT_W + 1);

  stage_st_e st_q, st_nx;

  logic [NUM_DN-1:0]      flags_nx, flags_q;
  logic [IN_W*TAG_W-1:0]  live_tags, push_data;
  logic [CW-1:0]          live_cnt;
  logic [OUT_W*TAG_W-1:0] rd_data;
  logic [LW-1:0]          level;
  logic                   ovf, clr_skid, blk, unblk, from_skid, stall_now, held;
  int                     live_i, level_i, out_i, pop_i, push_i;

  stall_flags #(.N(NUM_DN)) u_flags (
    .clk(clk), .rst(rst), .set_p(dn_hold), .clr_p(dn_release),
    .flags_nx(flags_nx), .flags_q(flags_q)
  );

  live_pack #(.TAG_W(TAG_W), .IN_W(IN_W)) u_pack (
    .in_count(in_count), .in_valid(in_valid), .in_squashed(in_squashed),
    .in_tags(in_tags), .live_tags(live_tags), .live_cnt(live_cnt)
  );

  skid_ring #(.TAG_W(TAG_W), .IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_skid (
    .clk(clk), .rst(rst), .clear(clr_skid),
    .push_n(CW'(push_i)), .push_data(push_data), .pop_n(OCW'(pop_i)),
    .rd_data(rd_data), .level(level), .ovf(ovf)
  );

  assign stall_now = |flags_nx;
  assign held      = (st_q == ST_HOLD) || (st_q == ST_DRAIN);
  assign live_i    = int'(live_cnt);
  assign level_i   = int'(level);

  always_comb begin
    st_nx     = st_q;
    out_i     = 0;
    pop_i     = 0;
    push_i    = 0;
    push_data = live_tags;
    from_skid = 1'b0;
    clr_skid  = 1'b0;
    blk       = 1'b0;
    unblk     = 1'b0;
    if (flush) begin
      clr_skid = 1'b1;
      unblk    = held;
      st_nx    = ST_FLUSH;
    end else if (flush_busy) begin
      clr_skid = 1'b1;
      st_nx    = ST_FLUSH;
    end else if (stall_now) begin
      blk    = !held;
      push_i = live_i;
      st_nx  = ST_HOLD;
    end else if (held) begin
      pop_i     = min_int(level_i, OUT_W);
      out_i     = pop_i;
      from_skid = 1'b1;
      push_i    = live_i;
      if (level_i - pop_i + live_i == 0) begin
        unblk = 1'b1;
        st_nx = ST_RUN;
      end else begin
        st_nx = ST_DRAIN;
      end
    end else begin
      out_i = min_int(live_i, OUT_W);
      if (live_i > OUT_W) begin
        push_i    = live_i - OUT_W;
        push_data = live_tags >> (OUT_W * TAG_W);
        blk       = 1'b1;
        st_nx     = ST_HOLD;
      end else if (st_q != ST_IDLE || live_i != 0) begin
        st_nx = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      out_valid  <= '0;
      out_tags   <= '0;
      up_hold    <= 1'b0;
      up_release <= 1'b0;
      ovf_err    <= 1'b0;
    end else begin
      st_q       <= st_nx;
      up_hold    <= blk;
      up_release <= unblk;
      ovf_err    <= ovf_err | ovf;
      for (int k = 0; k < OUT_W; k++) begin
        out_valid[k] <= (k < out_i);
        out_tags[k*TAG_W +: TAG_W] <= from_skid ? rd_data[k*TAG_W +: TAG_W]
                                                : live_tags[k*TAG_W +: TAG_W];
      end
    end
  end

  assign state = st_q;

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(up_hold && up_release)); // R11
  AST_NO_REHOLD: assert property (@(posedge clk) disable iff (rst)
    held |=> !up_hold); // R5
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (rst)
    stall_now |=> (out_valid == '0)); // R5
  AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    up_release |-> (level == '0)); // R7
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (st_q == ST_FLUSH && out_valid == '0)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err); // R10

endmodule

// File: tb/skid_stage_ctl_test.sv
module skid_stage_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8, IN_W = 4, OUT_W = 2, UP_DLY = 2;
  localparam int CW = $clog2(IN_W + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [CW-1:0] in_count = '0;
  logic [IN_W-1:0] in_squashed = '0;
  logic [IN_W*TW-1:0] in_tags = '0;
  logic [2:0] dn_hold = '0, dn_release = '0;
  logic flush = 1'b0, flush_busy = 1'b0;
  logic [OUT_W-1:0] out_valid;
  logic [OUT_W*TW-1:0] out_tags;
  logic up_hold, up_release, ovf_err;
  logic [2:0] state;

  int n_chk = 0, n_bad = 0;
  logic [TW-1:0] next_tag = 8'd1;
  logic [TW-1:0] exp_q [$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skid_stage_ctl #(.TAG_W(TW), .IN_W(IN_W), .OUT_W(OUT_W), .UP_DLY(UP_DLY)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_count(in_count),
    .in_squashed(in_squashed), .in_tags(in_tags), .dn_hold(dn_hold),
    .dn_release(dn_release), .flush(flush), .flush_busy(flush_busy),
    .out_valid(out_valid), .out_tags(out_tags), .up_hold(up_hold),
    .up_release(up_release), .state(state), .ovf_err(ovf_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for each valid slot, slot 0 first (R2, R6)
  task automatic monitor();
    for (int k = 0; k < OUT_W; k++) begin
      if (out_valid[k]) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected tag", int'(out_tags[k*TW +: TW]), -1);
        end else begin
          check("R2/R6 tag order", int'(out_tags[k*TW +: TW]), int'(exp_q.pop_front()));
        end
      end
    end
    check("R11 pulses exclusive", int'(up_hold && up_release), 0);
  endtask

  // driver: applies one cycle of stimulus, queues the tags that must emerge
  task automatic step(input int n, input logic [IN_W-1:0] sqm, input logic [2:0] hs,
                      input logic [2:0] rl, input logic fl, input logic fb, input int keep);
    int kept;
    kept = 0;
    if (fl) exp_q.delete();
    in_valid = (n > 0);
    in_count = CW'(n);
    in_squashed = sqm;
    for (int i = 0; i < IN_W; i++) begin
      in_tags[i*TW +: TW] = next_tag;
      if (i < n && !sqm[i] && kept < keep) begin
        exp_q.push_back(next_tag);
        kept++;
      end
      next_tag = next_tag + 8'd1;
    end
    dn_hold = hs; dn_release = rl; flush = fl; flush_busy = fb;
    @(posedge clk);
    #1;
    monitor();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 state", int'(state), 0);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 hold", int'(up_hold), 0);
    check("R1 release", int'(up_release), 0);
    check("R1 err", int'(ovf_err), 0);
    step(0, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    check("R1 idle stays", int'(state), 0);

    step(2, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    check("R2 two slots", int'(out_valid), 3);
    check("R2 running", int'(state), 1);

    step(3, 4'b0010, 3'b0, 3'b0, 0, 0, 99);
    check("R3 squashed skipped", int'(out_valid), 3);
    check("R3 no hold", int'(up_hold), 0);

    step(4, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    check("R4 hold pulse", int'(up_hold), 1);
    check("R4 blocked", int'(state), 2);
    step(0, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    check("R7 release after drain", int'(up_release), 1);
    check("R7 running", int'(state), 1);

    step(2, 4'b0, 3'b001, 3'b0, 0, 0, 99);
    check("R5 no output", int'(out_valid), 0);
    check("R5 first hold", int'(up_hold), 1);
    check("R5 blocked", int'(state), 2);
    step(3, 4'b0, 3'b100, 3'b0, 0, 0, 99);
    check("R5 no second hold", int'(up_hold), 0);
    step(1, 4'b0, 3'b0, 3'b001, 0, 0, 99);
    check("R5 one flag still set", int'(state), 2);
    check("R5 still silent", int'(out_valid), 0);
    step(0, 4'b0, 3'b0, 3'b100, 0, 0, 99);
    check("R6 unblocking", int'(state), 3);
    check("R6 drains two", int'(out_valid), 3);
    check("R6 no early release", int'(up_release), 0);
    step(2, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    check("R6 input appended", int'(state), 3);
    step(0, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    step(0, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    check("R7 release", int'(up_release), 1);
    check("R7 back to running", int'(state), 1);

    step(3, 4'b0, 3'b010, 3'b0, 0, 0, 99);
    check("R8 setup blocked", int'(state), 2);
    step(2, 4'b0, 3'b0, 3'b010, 1, 0, 0);
    check("R8 squashing", int'(state), 4);
    check("R8 release", int'(up_release), 1);
    check("R8 nothing out", int'(out_valid), 0);
    step(2, 4'b0, 3'b0, 3'b0, 0, 1, 0);
    check("R9 stays squashing", int'(state), 4);
    check("R9 input dropped", int'(out_valid), 0);
    step(2, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    check("R9 running", int'(state), 1);
    check("R9 forwarded", int'(out_valid), 3);

    step(4, 4'b0, 3'b001, 3'b0, 0, 0, 99);
    step(4, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    check("R10 no error at 8", int'(ovf_err), 0);
    step(4, 4'b0, 3'b0, 3'b0, 0, 0, 2);
    check("R10 overflow", int'(ovf_err), 1);
    step(0, 4'b0, 3'b0, 3'b001, 0, 0, 99);
    check("R10 sticky", int'(ovf_err), 1);
    for (int j = 0; j < 4; j++) step(0, 4'b0, 3'b0, 3'b0, 0, 0, 99);
    check("R7 release after full drain", int'(up_release), 1);
    check("R10 still set", int'(ovf_err), 1);
    check("R6 scoreboard empty", exp_q.size(), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule